// File: doc/BRIEF.md
# SD Sampling-Point Tuning Sequencer

This block is the host-side controller that walks an SD or SDIO card through the sampling-point tuning procedure at UHS-I speeds. A one-cycle `start` pulse hands it the selected bus speed mode. If that mode needs tuning, the block prepares the host for a tuning transfer. It enables only the buffer-read-ready interrupt, forces a 64-byte single-block transfer with DMA off and sets execute-tuning. It then issues the tuning command and waits for the data path to report that a tuning block has arrived and whether it matched. If the mode does not need tuning, the block finishes in one cycle and issues nothing.

The command leaves the block over a valid/ready handshake. `cmd_valid` rises with the index and flags already on their pins. All three hold steady until the consumer raises `cmd_ready`. The command counts as issued in the cycle where both are high, and the consumer may stall for any number of cycles. Every other pin is a plain level or pulse.

A tuning block that matches ends the run: execute-tuning clears and sampling-clock-select is set. A block that does not match causes the command to be issued again, up to a fixed number of attempts. If the buffer-read-ready event does not arrive in time, or if every attempt fails, the block falls back to the fixed sampling clock by clearing both control bits. When the run ends, the interrupt mask that was in use before the run is put back, and a one-cycle `done` pulse is raised with sticky status bits beside it.

Top module: `sd_tune_seq`

## Requirements
- R1: Speed mode encoding: 0 SDR12, 1 SDR25, 2 SDR50, 3 SDR104, 4 DDR50, and 5 to 7 unused. A start runs tuning for mode 3, and for mode 2 only when `sdr50_tune_req` is 1. Any other start raises `done` in the next cycle with `busy`, `cmd_valid`, `tuned_ok` and `fell_back` all 0.
- R2: While `busy` is high, `irq_en` has only bit 5 set (buffer-read-ready). After the run it equals the `irq_mask_in` value sampled at the accepted start.
- R3: While `busy` is high, `blk_size` is 64 and `dma_en` and `multi_blk` are 0. When idle, `dma_en` and `multi_blk` follow `host_dma_en` and `host_multi_blk`.
- R4: The command is offered with `cmd_valid` high, `cmd_index` = 19 and `cmd_flags` bit 5 (data present) set. Valid, index and flags stay unchanged until `cmd_ready` is high, and the handshake cycle issues exactly one command.
- R5: A `buf_rd_rdy` with `blk_pass` = 1 ends the run in the next cycle with `done` = 1, `tuned_ok` = 1, `exec_tune` = 0 and `smpl_clk_sel` = 1.
- R6: A `buf_rd_rdy` with `blk_pass` = 0 re-offers the command in the next cycle. The 40th failing block instead ends the run with `fell_back` = 1 and `exec_tune` and `smpl_clk_sel` both 0.
- R7: If `tick` is seen `timeout_ticks` times (0 counts as 1) after a command handshake with no `buf_rd_rdy`, the run ends in the next cycle with `fell_back` = 1 and both control bits 0. The count restarts at every handshake, and a `buf_rd_rdy` in the same cycle as the final tick takes precedence.
- R8: `clk_hold` is high for the whole run when `is_sdio` was 1 at the accepted start. Otherwise it stays 0.
- R9: A start while `busy` is high is ignored: it changes neither the saved mask, the run nor `done`.
- R10: From the accepted start until the run ends, `exec_tune` = 1 and `smpl_clk_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the tuning decision and procedure |
| speed_mode | input | 3 | Selected bus speed mode (see R1) |
| sdr50_tune_req | input | 1 | Capability: SDR50 needs tuning |
| is_sdio | input | 1 | Card is SDIO; keep its clock running |
| tick | input | 1 | Timer tick for the timeout |
| timeout_ticks | input | TMO_W | Ticks allowed per attempt |
| irq_mask_in | input | IRQ_W | Current interrupt-enable mask to save |
| host_dma_en | input | 1 | Host DMA-enable setting, passed through when idle |
| host_multi_blk | input | 1 | Host multi-block setting, passed through when idle |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_index | output | 6 | Command index, 19 while offered |
| cmd_flags | output | 8 | Command flags, bit 5 = data present |
| buf_rd_rdy | input | 1 | Tuning block received event |
| blk_pass | input | 1 | Compare result qualifying buf_rd_rdy |
| blk_size | output | BLK_W | Block size in bytes |
| dma_en | output | 1 | Transfer-mode DMA enable |
| multi_blk | output | 1 | Transfer-mode multi-block select |
| irq_en | output | IRQ_W | Interrupt-enable mask |
| exec_tune | output | 1 | Execute-tuning control bit |
| smpl_clk_sel | output | 1 | Sampling-clock-select control bit |
| clk_hold | output | 1 | Keep card clock ungated |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| tuned_ok | output | 1 | Last run ended on a matching block |
| fell_back | output | 1 | Last run fell back to the fixed sampling clock |

## Verification
The assertions assume that the consumer never withdraws `cmd_ready` in a way that matters: only the handshake cycle counts. They also assume that `buf_rd_rdy` arrives only while a command is outstanding, and that `blk_pass` is meaningful only in that cycle. The stimulus raises `buf_rd_rdy` only after a completed handshake and leaves it low at all other times. It pulses `start` for a single cycle, except in the deliberate start-while-busy case. It keeps `timeout_ticks` stable throughout a run, so the timeout window is well defined.

// File: rtl/sd_tune_pkg.sv
package sd_tune_pkg;
  typedef enum logic [2:0] {
    SPD_SDR12  = 3'd0,
    SPD_SDR25  = 3'd1,
    SPD_SDR50  = 3'd2,
    SPD_SDR104 = 3'd3,
    SPD_DDR50  = 3'd4
  } spd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } tune_state_e;
endpackage

// File: rtl/sd_tune_gate.sv
module sd_tune_gate
  import sd_tune_pkg::*;
(
  input  logic [2:0] speed_mode,
  input  logic       sdr50_tune_req,
  output logic       need_tune
);
  always_comb begin
    unique case (speed_mode)
      SPD_SDR104: need_tune = 1'b1;
      SPD_SDR50:  need_tune = sdr50_tune_req;
      default:    need_tune = 1'b0;
    endcase
  end
endmodule

// File: rtl/sd_tune_timer.sv
module sd_tune_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] tmo,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q <= TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (tmo == '0) ? TMO_W'(1) : tmo;
    end else if (run && tick && cnt_q > TMO_W'(1)) begin
      cnt_q <= cnt_q - TMO_W'(1);
    end
  end
endmodule

// File: rtl/sd_tune_iter.sv
module sd_tune_iter #(
  parameter int MAX_ITER = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);
  localparam int IW = $clog2(MAX_ITER + 1);
  logic [IW-1:0] cnt_q;

  assign last = (cnt_q == IW'(MAX_ITER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (bump)   cnt_q <= cnt_q + IW'(1);
  end
endmodule

// File: rtl/sd_tune_seq.sv
module sd_tune_seq
  import sd_tune_pkg::*;
#(
  parameter int TMO_W         = 16,
  parameter int MAX_ITER      = 40,
  parameter int IRQ_W         = 16,
  parameter int RDY_BIT       = 5,
  parameter int BLK_W         = 12,
  parameter int BLK_BYTES     = 64,
  parameter int CMD_IDX       = 19,
  parameter int DATA_FLAG_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       speed_mode,
  input  logic             sdr50_tune_req,
  input  logic             is_sdio,
  input  logic             tick,
  input  logic [TMO_W-1:0] timeout_ticks,
  input  logic [IRQ_W-1:0] irq_mask_in,
  input  logic             host_dma_en,
  input  logic             host_multi_blk,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [5:0]       cmd_index,
  output logic [7:0]       cmd_flags,
  input  logic             buf_rd_rdy,
  input  logic             blk_pass,
  output logic [BLK_W-1:0] blk_size,
  output logic             dma_en,
  output logic             multi_blk,
  output logic [IRQ_W-1:0] irq_en,
  output logic             exec_tune,
  output logic             smpl_clk_sel,
  output logic             clk_hold,
  output logic             busy,
  output logic             done,
  output logic             tuned_ok,
  output logic             fell_back
);
  localparam logic [IRQ_W-1:0] RDY_MASK = IRQ_W'(1) << RDY_BIT;
  localparam logic [7:0]       FLAGS    = 8'(1) << DATA_FLAG_BIT;

  tune_state_e      state_q;
  logic [IRQ_W-1:0] saved_q;
  logic             need_tune, expire, last_try;
  logic             take_start, handshake, got_blk;

  sd_tune_gate u_gate (
    .speed_mode     (speed_mode),
    .sdr50_tune_req (sdr50_tune_req),
    .need_tune      (need_tune)
  );

  sd_tune_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (handshake),
    .tmo    (timeout_ticks),
    .run    (state_q == ST_WAIT),
    .tick   (tick),
    .expire (expire)
  );

  sd_tune_iter #(.MAX_ITER(MAX_ITER)) u_iter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (take_start),
    .bump  (got_blk && !blk_pass),
    .last  (last_try)
  );

  assign take_start = (state_q == ST_IDLE) && start;
  assign handshake  = (state_q == ST_ISSUE) && cmd_ready;
  assign got_blk    = (state_q == ST_WAIT) && buf_rd_rdy;
  assign busy       = (state_q != ST_IDLE);
  assign cmd_valid  = (state_q == ST_ISSUE);
  assign cmd_index  = cmd_valid ? 6'(CMD_IDX) : 6'd0;
  assign cmd_flags  = cmd_valid ? FLAGS : 8'd0;
  assign dma_en     = busy ? 1'b0 : host_dma_en;
  assign multi_blk  = busy ? 1'b0 : host_multi_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      saved_q      <= '0;
      irq_en       <= '0;
      blk_size     <= '0;
      exec_tune    <= 1'b0;
      smpl_clk_sel <= 1'b0;
      clk_hold     <= 1'b0;
      done         <= 1'b0;
      tuned_ok     <= 1'b0;
      fell_back    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            tuned_ok  <= 1'b0;
            fell_back <= 1'b0;
            if (need_tune) begin
              state_q      <= ST_ISSUE;
              saved_q      <= irq_mask_in;
              irq_en       <= RDY_MASK;
              blk_size     <= BLK_W'(BLK_BYTES);
              exec_tune    <= 1'b1;
              smpl_clk_sel <= 1'b0;
              clk_hold     <= is_sdio;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (buf_rd_rdy && !blk_pass && !last_try) begin
            state_q <= ST_ISSUE;
          end else if (buf_rd_rdy || expire) begin
            state_q      <= ST_IDLE;
            done         <= 1'b1;
            irq_en       <= saved_q;
            clk_hold     <= 1'b0;
            exec_tune    <= 1'b0;
            smpl_clk_sel <= buf_rd_rdy && blk_pass;
            tuned_ok     <= buf_rd_rdy && blk_pass;
            fell_back    <= !(buf_rd_rdy && blk_pass);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_tune_seq_chk.sv
module sd_tune_seq_chk #(
  parameter int IRQ_W   = 16,
  parameter int RDY_BIT = 5,
  parameter int BLK_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [5:0]       cmd_index,
  input logic [7:0]       cmd_flags,
  input logic [BLK_W-1:0] blk_size,
  input logic             dma_en,
  input logic             multi_blk,
  input logic [IRQ_W-1:0] irq_en,
  input logic             exec_tune,
  input logic             smpl_clk_sel,
  input logic             clk_hold,
  input logic             busy,
  input logic             done,
  input logic             tuned_ok,
  input logic             fell_back
);
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_flags));
  assert_cmd_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_index == 6'd19 && cmd_flags[5]);
  assert_irq_only_rdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_en == (IRQ_W'(1) << RDY_BIT));
  assert_xfer_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> blk_size == BLK_W'(64) && !dma_en && !multi_blk);
  assert_ctrl_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> exec_tune && !smpl_clk_sel);
  assert_clk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !clk_hold);
  assert_pass_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && tuned_ok |-> !exec_tune && smpl_clk_sel);
  assert_fallback_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fell_back |-> !exec_tune && !smpl_clk_sel);
  assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tuned_ok && fell_back));
  assert_run_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind sd_tune_seq sd_tune_seq_chk #(
  .IRQ_W(IRQ_W), .RDY_BIT(RDY_BIT), .BLK_W(BLK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_index(cmd_index), .cmd_flags(cmd_flags),
  .blk_size(blk_size), .dma_en(dma_en), .multi_blk(multi_blk),
  .irq_en(irq_en), .exec_tune(exec_tune), .smpl_clk_sel(smpl_clk_sel),
  .clk_hold(clk_hold), .busy(busy), .done(done),
  .tuned_ok(tuned_ok), .fell_back(fell_back)
);

// File: tb/sd_tune_seq_tb.sv
module sd_tune_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  speed_mode = 3'd0;
  logic        sdr50_tune_req = 1'b0;
  logic        is_sdio = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] timeout_ticks = 16'd4;
  logic [15:0] irq_mask_in = 16'h0000;
  logic        host_dma_en = 1'b0;
  logic        host_multi_blk = 1'b0;
  logic        cmd_ready = 1'b0;
  logic        buf_rd_rdy = 1'b0;
  logic        blk_pass = 1'b0;
  logic        cmd_valid, dma_en, multi_blk, exec_tune, smpl_clk_sel;
  logic        clk_hold, busy, done, tuned_ok, fell_back;
  logic [5:0]  cmd_index;
  logic [7:0]  cmd_flags;
  logic [11:0] blk_size;
  logic [15:0] irq_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sd_tune_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .speed_mode(speed_mode),
    .sdr50_tune_req(sdr50_tune_req), .is_sdio(is_sdio), .tick(tick),
    .timeout_ticks(timeout_ticks), .irq_mask_in(irq_mask_in),
    .host_dma_en(host_dma_en), .host_multi_blk(host_multi_blk),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
    .cmd_flags(cmd_flags), .buf_rd_rdy(buf_rd_rdy), .blk_pass(blk_pass),
    .blk_size(blk_size), .dma_en(dma_en), .multi_blk(multi_blk),
    .irq_en(irq_en), .exec_tune(exec_tune), .smpl_clk_sel(smpl_clk_sel),
    .clk_hold(clk_hold), .busy(busy), .done(done), .tuned_ok(tuned_ok),
    .fell_back(fell_back)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // pulse start; leaves state one cycle after the accepted edge
  task automatic kick(input logic [2:0] m, input logic req50, input logic sdio,
                      input logic [15:0] mask);
    speed_mode = m; sdr50_tune_req = req50; is_sdio = sdio; irq_mask_in = mask;
    start = 1'b1;
    cyc();
    start = 1'b0;
  endtask

  // hold off ready for 'stall' cycles, checking the offer stays put, then handshake
  task automatic issue(input int stall);
    for (int i = 0; i < stall; i++) begin
      chk("R4 valid held", {cmd_valid, cmd_index, cmd_flags}, {1'b1, 6'd19, 8'h20});
      cyc();
    end
    chk("R4 offer", {cmd_valid, cmd_index, cmd_flags[5]}, {1'b1, 6'd19, 1'b1});
    cmd_ready = 1'b1;
    cyc();
    cmd_ready = 1'b0;
    chk("R4 one command", cmd_valid, 1'b0);
  endtask

  task automatic block(input logic p);
    buf_rd_rdy = 1'b1; blk_pass = p;
    cyc();
    buf_rd_rdy = 1'b0; blk_pass = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("reset state", {busy, done, cmd_valid, exec_tune, smpl_clk_sel, clk_hold, irq_en},
        {6'b0, 16'h0});

    // R1: sweep all modes and capability values
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 2; r++) begin
        logic need;
        need = (m == 3) || (m == 2 && r == 1);
        kick(3'(m), 1'(r), 1'b0, 16'hA5A5);
        chk("R1 busy by mode", busy, need);
        chk("R1 done by mode", done, !need);
        if (need) begin
          chk("R10 bits at start", {exec_tune, smpl_clk_sel}, 2'b10);
          chk("R2 only rdy irq", irq_en, 16'h0020);
          issue(m);
          block(1'b1);
          chk("R5 pass end", {done, tuned_ok, fell_back, exec_tune, smpl_clk_sel}, 5'b11001);
          chk("R2 mask restored", irq_en, 16'hA5A5);
        end else begin
          chk("R1 no command", {cmd_valid, tuned_ok, fell_back}, 3'b000);
        end
        cyc();
        chk("R1 done pulse", done, 1'b0);
      end
    end

    // R3 idle pass-through and forced values while busy
    host_dma_en = 1'b1; host_multi_blk = 1'b1;
    #1 chk("R3 idle follow", {dma_en, multi_blk}, 2'b11);
    kick(3'd3, 1'b0, 1'b1, 16'h1234);
    chk("R3 forced", {blk_size, dma_en, multi_blk}, {12'd64, 2'b00});
    chk("R8 sdio hold", clk_hold, 1'b1);
    // R9: start while busy ignored
    irq_mask_in = 16'hFFFF; speed_mode = 3'd0; start = 1'b1;
    cyc();
    start = 1'b0;
    chk("R9 ignored", {busy, done, cmd_valid}, 3'b101);
    issue(0);
    // R6: fail k times then pass
    for (int k = 0; k < 3; k++) begin
      block(1'b0);
      chk("R6 reissue", {cmd_valid, busy, done}, 3'b110);
      chk("R8 hold kept", clk_hold, 1'b1);
      issue(1);
    end
    block(1'b1);
    chk("R9 mask from accepted start", irq_en, 16'h1234);
    chk("R8 hold released", clk_hold, 1'b0);
    chk("R3 idle again", {dma_en, multi_blk}, 2'b11);
    host_dma_en = 1'b0; host_multi_blk = 1'b0;
    cyc();

    // R6: 40 failing attempts exhaust the budget
    kick(3'd2, 1'b1, 1'b0, 16'h00F0);
    chk("R8 no hold non-sdio", clk_hold, 1'b0);
    for (int k = 1; k <= 40; k++) begin
      issue(0);
      block(1'b0);
      if (k < 40) chk("R6 still busy", busy, 1'b1);
    end
    chk("R6 exhausted", {done, busy, tuned_ok, fell_back, exec_tune, smpl_clk_sel}, 6'b100100);
    chk("R6 mask restored", irq_en, 16'h00F0);
    cyc();

    // R7: timeout after exactly T ticks, T in 0..6
    for (int t = 0; t < 7; t++) begin
      int eff;
      eff = (t == 0) ? 1 : t;
      timeout_ticks = 16'(t);
      kick(3'd3, 1'b0, 1'b0, 16'h0F0F);
      issue(0);
      tick = 1'b1;
      for (int i = 1; i < eff; i++) cyc();
      chk("R7 not yet", {busy, done}, 2'b10);
      cyc();
      tick = 1'b0;
      chk("R7 timeout", {done, busy, fell_back, exec_tune, smpl_clk_sel}, 5'b10100);
      cyc();
    end

    // R7: reload per attempt, and block wins on final tick
    timeout_ticks = 16'd3;
    kick(3'd3, 1'b0, 1'b0, 16'h0001);
    issue(0);
    tick = 1'b1; cyc(); cyc(); tick = 1'b0;
    block(1'b0);
    issue(0);
    tick = 1'b1; cyc(); cyc();
    chk("R7 reloaded", {busy, done}, 2'b10);
    buf_rd_rdy = 1'b1; blk_pass = 1'b1;
    cyc();
    tick = 1'b0; buf_rd_rdy = 1'b0; blk_pass = 1'b0;
    chk("R7 block beats tick", {done, tuned_ok, fell_back}, 3'b110);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule